// File: doc/BRIEF.md
# Output-Side Cell Resequencer for a Two-Stage Load-Balanced Switch

This block sits at one output port of a two-stage load-balanced switch. Each source input spreads its cells for this output across the middle-stage queues in strict rotation. As a result, the cells of one flow can reach this output in the wrong order. The block restores the order without using sequence numbers. It relies only on the rotation: for every source it knows which middle-stage index must supply the next cell. Cells are parked in per-source slots addressed by (source, middle index).

A source whose awaited cell is present becomes ready. Its number is pushed onto a short queue of source indices, and that queue alone picks the next departure. Each decision is therefore a fixed amount of work, whatever the port count. When a cell leaves, the source's awaited index moves one step around the ring. If the cell at the new index is already parked, the source goes straight back onto the queue.

Both data interfaces use valid/ready. On the arrival side, `in_ready` is a combinational function of the addressed slot: it is low only while that (source, middle index) slot still holds a cell. A cell offered while `in_ready` is low is not taken and must be offered again. On the departure side, the outputs hold steady while `out_valid` is high and `out_ready` is low. A cell leaves on any clock edge where both are high.

Top module: `lbr_reseq`

## Requirements
- R1: After reset, `out_valid` is 0, every slot is empty (`in_ready` is 1 for any address), and every source awaits middle index 0. This also holds after a reset applied mid-run.
- R2: An accepted cell whose middle index equals its source's awaited index is queued when its source is not already queued. With the departure queue empty, it is presented on the next cycle with `out_src`, `out_ctr` and `out_data` equal to the arriving source, middle index and payload.
- R3: A cell whose middle index differs from its source's awaited index is stored but not presented. It stays hidden until every earlier cell of that flow has left.
- R4: When a cell of source s departs, s's awaited index advances by one, wrapping from N-1 to 0. If the cell for the new index is already stored, or arrives in that same cycle, s is presented again without any further arrival.
- R5: Sources are released in the order in which they were queued. `out_src` is always a source whose flag is set in the departure queue.
- R6: At most one cell departs per cycle. While `out_valid` is 1 and `out_ready` is 0, `out_src`, `out_ctr` and `out_data` stay unchanged.
- R7: `in_ready` is 0 exactly when the addressed slot is occupied. A cell offered to an occupied slot is ignored: the parked payload is what departs later.
- R8: The departure queue holds up to N entries, one per source. With all N sources ready at once, all N are released in queue order and none is lost.
- R9: If a departure re-queues its own source in the same cycle that an arrival makes another source ready, the re-queued source is placed ahead of the newly ready one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Arrival cell offered |
| in_ready | output | 1 | Addressed slot is free; cell taken when both are high |
| in_src | input | $clog2(N) | Source input of the arriving cell |
| in_ctr | input | $clog2(N) | Middle-stage index that carried the cell |
| in_data | input | DW | Cell payload |
| out_valid | output | 1 | A cell is presented for departure |
| out_ready | input | 1 | Downstream accepts the presented cell |
| out_src | output | $clog2(N) | Source of the presented cell |
| out_ctr | output | $clog2(N) | Middle-stage index of the presented cell |
| out_data | output | DW | Payload of the presented cell |

## Verification
The hardest case to reach from the ports is a double push into the departure queue. This happens when a departing source finds its next cell already parked while a different source becomes ready in the same cycle. The stimulus gets there by first parking two consecutive cells for one source and holding `out_ready` low. It then offers another source's awaited cell on the exact cycle the first source's head leaves. A variant delivers the departing source's next cell in that same cycle, and a full test readies all N sources behind a stalled output.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  // One step around a ring of n positions.
  function automatic int ring_step(int v, int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/lbr_cell_store.sv
module lbr_cell_store #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int SW = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SW-1:0]           wr_src,
  input  logic [SW-1:0]           wr_ctr,
  input  logic [DW-1:0]           wr_data,
  input  logic                    clr_en,
  input  logic [SW-1:0]           clr_src,
  input  logic [SW-1:0]           clr_ctr,
  input  logic [SW-1:0]           rd_src,
  input  logic [SW-1:0]           rd_ctr,
  output logic [DW-1:0]           rd_data,
  output logic [N-1:0][N-1:0]     occ
);
  logic [DW-1:0] mem [N][N];

  for (genvar s = 0; s < N; s++) begin : g_src
    for (genvar c = 0; c < N; c++) begin : g_ctr
      logic hit_wr, hit_clr;
      assign hit_wr  = wr_en  && wr_src  == SW'(s) && wr_ctr  == SW'(c);
      assign hit_clr = clr_en && clr_src == SW'(s) && clr_ctr == SW'(c);

      always_ff @(posedge clk) begin
        if (!rst_n)       occ[s][c] <= 1'b0;
        else if (hit_wr)  occ[s][c] <= 1'b1;
        else if (hit_clr) occ[s][c] <= 1'b0;
      end

      always_ff @(posedge clk) begin
        if (hit_wr) mem[s][c] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_src][rd_ctr];
endmodule

// File: rtl/lbr_flow_track.sv
module lbr_flow_track #(
  parameter int N  = 4,
  parameter int SW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arr_fire,
  input  logic [SW-1:0]        arr_src,
  input  logic [SW-1:0]        arr_ctr,
  input  logic                 dep_fire,
  input  logic [SW-1:0]        dep_src,
  input  logic [N-1:0][N-1:0]  occ,
  output logic [N-1:0][SW-1:0] want_ctr,
  output logic [N-1:0]         queued,
  output logic                 push_re,
  output logic                 push_new
);
  logic [SW-1:0] nxt;
  logic          nxt_full;

  assign nxt      = SW'(lbr_pkg::ring_step(int'(want_ctr[dep_src]), N));
  assign nxt_full = occ[dep_src][nxt] ||
                    (arr_fire && arr_src == dep_src && arr_ctr == nxt);
  assign push_re  = dep_fire && nxt_full;
  assign push_new = arr_fire && arr_ctr == want_ctr[arr_src] && !queued[arr_src];

  for (genvar s = 0; s < N; s++) begin : g_flow
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        want_ctr[s] <= '0;
        queued[s]   <= 1'b0;
      end else if (dep_fire && dep_src == SW'(s)) begin
        want_ctr[s] <= nxt;
        queued[s]   <= push_re;
      end else if (push_new && arr_src == SW'(s)) begin
        queued[s]   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lbr_depart_fifo.sv
module lbr_depart_fifo #(
  parameter int N  = 4,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_a,
  input  logic [SW-1:0] a_val,
  input  logic          push_b,
  input  logic [SW-1:0] b_val,
  input  logic          pop,
  output logic [SW-1:0] head,
  output logic [SW:0]   cnt,
  output logic          nonempty
);
  logic [SW-1:0] slot [N];
  logic [SW-1:0] rp, wp, wp_b, wp_n;

  // Push A always lands first, so a same-cycle push B sits behind it.
  assign wp_b = push_a ? SW'(lbr_pkg::ring_step(int'(wp), N)) : wp;
  assign wp_n = push_b ? SW'(lbr_pkg::ring_step(int'(wp_b), N)) : wp_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_n;
      if (pop) rp <= SW'(lbr_pkg::ring_step(int'(rp), N));
      cnt <= cnt + (SW+1)'(push_a) + (SW+1)'(push_b) - (SW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push_a) slot[wp]   <= a_val;
    if (push_b) slot[wp_b] <= b_val;
  end

  assign head     = slot[rp];
  assign nonempty = cnt != '0;
endmodule

// File: rtl/lbr_reseq.sv
module lbr_reseq #(
  parameter int N  = 4,
  parameter int DW = 8,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_src,
  input  logic [SW-1:0] in_ctr,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_src,
  output logic [SW-1:0] out_ctr,
  output logic [DW-1:0] out_data
);
  logic [N-1:0][N-1:0]  occ;
  logic [N-1:0][SW-1:0] want_ctr;
  logic [N-1:0]         q_flags;
  logic [SW:0]          fifo_cnt;
  logic [SW-1:0]        head;
  logic                 arr_fire, dep_fire, push_re, push_new, nonempty;

  assign in_ready  = !occ[in_src][in_ctr];
  assign arr_fire  = in_valid && in_ready;
  assign out_valid = nonempty;
  assign dep_fire  = out_valid && out_ready;
  assign out_src   = head;
  assign out_ctr   = want_ctr[head];

  lbr_cell_store #(.N(N), .DW(DW), .SW(SW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(arr_fire), .wr_src(in_src), .wr_ctr(in_ctr), .wr_data(in_data),
    .clr_en(dep_fire), .clr_src(head), .clr_ctr(want_ctr[head]),
    .rd_src(head), .rd_ctr(want_ctr[head]), .rd_data(out_data),
    .occ(occ)
  );

  lbr_flow_track #(.N(N), .SW(SW)) u_track (
    .clk(clk), .rst_n(rst_n),
    .arr_fire(arr_fire), .arr_src(in_src), .arr_ctr(in_ctr),
    .dep_fire(dep_fire), .dep_src(head), .occ(occ),
    .want_ctr(want_ctr), .queued(q_flags),
    .push_re(push_re), .push_new(push_new)
  );

  lbr_depart_fifo #(.N(N), .SW(SW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_a(push_re), .a_val(head),
    .push_b(push_new), .b_val(in_src),
    .pop(dep_fire), .head(head), .cnt(fifo_cnt), .nonempty(nonempty)
  );
endmodule

// File: rtl/lbr_reseq_chk.sv
module lbr_reseq_chk #(
  parameter int N  = 4,
  parameter int DW = 8,
  localparam int SW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [SW-1:0] out_src,
  input logic [SW-1:0] out_ctr,
  input logic [DW-1:0] out_data,
  input logic [SW:0]   fifo_cnt,
  input logic [N-1:0]  q_flags
);
  logic [N-1:0]         seen;
  logic [N-1:0][SW-1:0] prev;
  logic                 fire;

  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
      prev <= '0;
    end else if (fire) begin
      seen[out_src] <= 1'b1;
      prev[out_src] <= out_ctr;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_src) && $stable(out_ctr) && $stable(out_data)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= N);

  p_count_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) == $countones(q_flags));

  p_ring_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && seen[out_src]) |->
      int'(out_ctr) == lbr_pkg::ring_step(int'(prev[out_src]), N));

  p_head_flagged_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> q_flags[out_src]);
endmodule

bind lbr_reseq lbr_reseq_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_src(out_src), .out_ctr(out_ctr), .out_data(out_data),
  .fifo_cnt(fifo_cnt), .q_flags(q_flags)
);

// File: tb/sim_lbr_reseq.sv
module sim_lbr_reseq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [1:0] in_src = '0, in_ctr = '0, out_src, out_ctr;
  logic [7:0] in_data = '0, out_data;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbr_reseq #(.N(4), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
    .in_ctr(in_ctr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_src(out_src), .out_ctr(out_ctr), .out_data(out_data)
  );

  // {in_valid, src, ctr, data, out_ready, exp_valid, exp_src, exp_ctr, exp_data}
  localparam logic [26:0] VEC [NV] = '{
    {1'b1,2'd1,2'd1,8'h11,1'b1, 1'b0,2'd0,2'd0,8'h00}, // R3 held
    {1'b1,2'd1,2'd2,8'h12,1'b1, 1'b0,2'd0,2'd0,8'h00}, // R3 held
    {1'b1,2'd1,2'd0,8'h10,1'b1, 1'b0,2'd0,2'd0,8'h00}, // R1 awaited 0
    {1'b0,2'd0,2'd0,8'h00,1'b1, 1'b1,2'd1,2'd0,8'h10}, // R2
    {1'b0,2'd0,2'd0,8'h00,1'b1, 1'b1,2'd1,2'd1,8'h11}, // R4 requeue
    {1'b0,2'd0,2'd0,8'h00,1'b1, 1'b1,2'd1,2'd2,8'h12}, // R4
    {1'b1,2'd1,2'd3,8'h13,1'b1, 1'b0,2'd0,2'd0,8'h00},
    {1'b0,2'd0,2'd0,8'h00,1'b1, 1'b1,2'd1,2'd3,8'h13}, // R2
    {1'b1,2'd1,2'd0,8'h20,1'b1, 1'b0,2'd0,2'd0,8'h00}, // R4 wrap
    {1'b0,2'd0,2'd0,8'h00,1'b1, 1'b1,2'd1,2'd0,8'h20}, // R4 wrap
    {1'b1,2'd2,2'd0,8'h30,1'b0, 1'b0,2'd0,2'd0,8'h00},
    {1'b1,2'd0,2'd0,8'h40,1'b0, 1'b1,2'd2,2'd0,8'h30}, // R6 stall
    {1'b1,2'd3,2'd0,8'h50,1'b0, 1'b1,2'd2,2'd0,8'h30}, // R6 stall
    {1'b0,2'd0,2'd0,8'h00,1'b1, 1'b1,2'd2,2'd0,8'h30}, // R5 order
    {1'b0,2'd0,2'd0,8'h00,1'b1, 1'b1,2'd0,2'd0,8'h40}, // R5
    {1'b0,2'd0,2'd0,8'h00,1'b1, 1'b1,2'd3,2'd0,8'h50}, // R5
    {1'b1,2'd0,2'd1,8'h41,1'b1, 1'b0,2'd0,2'd0,8'h00},
    {1'b1,2'd0,2'd2,8'h42,1'b0, 1'b1,2'd0,2'd1,8'h41},
    {1'b1,2'd2,2'd1,8'h61,1'b1, 1'b1,2'd0,2'd1,8'h41}, // R9 double push
    {1'b0,2'd0,2'd0,8'h00,1'b1, 1'b1,2'd0,2'd2,8'h42}, // R9 requeued first
    {1'b0,2'd0,2'd0,8'h00,1'b1, 1'b1,2'd2,2'd1,8'h61}, // R9
    {1'b1,2'd3,2'd1,8'h71,1'b1, 1'b0,2'd0,2'd0,8'h00},
    {1'b1,2'd3,2'd2,8'h72,1'b1, 1'b1,2'd3,2'd1,8'h71}, // R4 same-cycle next
    {1'b0,2'd0,2'd0,8'h00,1'b1, 1'b1,2'd3,2'd2,8'h72}, // R4
    {1'b0,2'd0,2'd0,8'h00,1'b1, 1'b0,2'd0,2'd0,8'h00}  // R6 one per cycle
  };

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int s, input int c, input int d, input logic r);
    @(negedge clk);
    in_valid = v; in_src = 2'(s); in_ctr = 2'(c); in_data = 8'(d); out_ready = r;
    #1;
  endtask

  task automatic expect_out(input string rq, input int s, input int c, input int d);
    chk(rq, int'(out_valid), 1);
    chk(rq, int'(out_src), s);
    chk(rq, int'(out_ctr), c);
    chk(rq, int'(out_data), d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    drive(1'b0, 2, 3, 0, 1'b1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      logic [26:0] v;
      v = VEC[i];
      drive(v[26], int'(v[25:24]), int'(v[23:22]), int'(v[21:14]), v[13]);
      if (v[26]) chk("R7 free slot ready", int'(in_ready), 1);
      chk("R2 R3 valid", int'(out_valid), int'(v[12]));
      if (v[12]) begin
        chk("R5 src", int'(out_src), int'(v[11:10]));
        chk("R4 ctr", int'(out_ctr), int'(v[9:8]));
        chk("R2 data", int'(out_data), int'(v[7:0]));
      end
    end

    // R7: refused arrival to an occupied slot is ignored
    drive(1'b1, 1, 2, 'hA1, 1'b0);
    chk("R7 first take", int'(in_ready), 1);
    drive(1'b1, 1, 2, 'hEE, 1'b0);
    chk("R7 occupied", int'(in_ready), 0);
    chk("R3 hidden", int'(out_valid), 0);
    drive(1'b1, 1, 1, 'hA0, 1'b0);
    chk("R7 other slot", int'(in_ready), 1);
    drive(1'b0, 0, 0, 0, 1'b1);
    expect_out("R7 head", 1, 1, 'hA0);
    drive(1'b0, 0, 0, 0, 1'b1);
    expect_out("R7 parked kept", 1, 2, 'hA1);
    drive(1'b0, 0, 0, 0, 1'b1);
    chk("R7 drained", int'(out_valid), 0);

    // R8: all sources ready at once behind a stalled output
    drive(1'b1, 2, 2, 'hB2, 1'b0);
    drive(1'b1, 0, 3, 'hB0, 1'b0);
    drive(1'b1, 3, 3, 'hB3, 1'b0);
    drive(1'b1, 1, 3, 'hB1, 1'b0);
    drive(1'b0, 0, 0, 0, 1'b0);
    expect_out("R8 stalled head", 2, 2, 'hB2);
    drive(1'b0, 0, 0, 0, 1'b1);
    expect_out("R8 first", 2, 2, 'hB2);
    drive(1'b0, 0, 0, 0, 1'b1);
    expect_out("R8 second", 0, 3, 'hB0);
    drive(1'b0, 0, 0, 0, 1'b1);
    expect_out("R8 third", 3, 3, 'hB3);
    drive(1'b0, 0, 0, 0, 1'b1);
    expect_out("R8 fourth", 1, 3, 'hB1);
    drive(1'b0, 0, 0, 0, 1'b1);
    chk("R8 empty", int'(out_valid), 0);

    // R1: mid-run reset clears slots and awaited indices
    drive(1'b1, 0, 1, 'hC1, 1'b0);
    drive(1'b0, 0, 0, 0, 1'b0);
    rst_n = 1'b0;
    drive(1'b0, 0, 0, 0, 1'b0);
    rst_n = 1'b1;
    drive(1'b1, 0, 1, 'hD1, 1'b0);
    chk("R1 slot cleared", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    drive(1'b1, 2, 0, 'hD2, 1'b1);
    chk("R1 no release", int'(out_valid), 0);
    drive(1'b0, 0, 0, 0, 1'b1);
    expect_out("R1 awaited 0", 2, 0, 'hD2);
    drive(1'b0, 0, 0, 0, 1'b1);
    chk("R1 done", int'(out_valid), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule